// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns one serial audio data line into parallel samples. It runs as a slave: the bit clock and the frame sync both come from outside the block. A 2-bit select picks one of four incoming data lines. A 3-bit format code picks how the bits in a frame are read. The supported formats are:

- I2S
- left-justified
- four right-justified word lengths
- time-division multiplexed (TDM) frames of 8 or 16 slots

For every channel it receives, the block outputs a 24-bit left-aligned sample word, a channel number and a one-cycle valid strobe.

The bit clock, the frame sync and the selected data line are passed through the same two-flop synchronizer into the system clock domain. The edges are detected in that domain. Configuration bits set which bit-clock edge samples the data and which frame-sync level marks the left channel. The system clock must run at four or more times the bit clock. The configuration is meant to be held stable while a stream is running.

Top module: `aud_ser_rx`

## Requirements
- R1: Format code 3'b000 (I2S). The MSB of each channel is the second bit after a frame-sync transition. The 24 bits that follow it are captured MSB first.
- R2: Format code 3'b001 (left-justified). The MSB is the first bit sampled after a frame-sync transition.
- R3: Format codes 3'b011, 3'b100, 3'b101 and 3'b110 are right-justified with 24, 20, 18 and 16 bits.
  - The last bit before a frame-sync transition is the LSB of the channel that just ended.
  - The sample is output left-aligned in 24 bits, with zeros in the low bits.
- R4: Format code 3'b010 (TDM).
  - A frame starts at the frame-sync transition into its active level. The active level is the level opposite to `cfg_fs_pol`.
  - Each slot is 32 bits, and slot k carries its MSB-first word in its first 24 bits.
  - Slots are numbered 0 upward on `smp_chan`.
  - `cfg_tdm16`=0 gives 8 channels and =1 gives 16. Slots beyond that count produce nothing.
- R5: In the two-channel formats, the left channel (`smp_chan`=0) is framed by frame sync equal to `cfg_fs_pol`. The right channel (`smp_chan`=1) is framed by the opposite level.
- R6: With `cfg_bclk_pol`=0, data changes on the falling bit-clock edge and is sampled on the rising edge. With 1, data changes on the rising edge and is sampled on the falling edge.
- R7: `cfg_line_sel` codes 0, 1, 2 and 3 choose data lines 3, 2, 1 and 0. The unselected lines have no effect on the output.
- R8: `smp_valid` is high for exactly one system-clock cycle for each completed channel. Format code 3'b111 is reserved and never raises `smp_valid`.
- R9: While `rst_n` is low, and after it rises, the outputs are zero. No sample is output before a frame-sync transition has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External frame sync |
| sdata_i | input | 4 | Four serial data lines |
| cfg_mode | input | 3 | Format code |
| cfg_tdm16 | input | 1 | TDM channel count: 0 = 8, 1 = 16 |
| cfg_fs_pol | input | 1 | Frame-sync level that marks the left channel |
| cfg_bclk_pol | input | 1 | Bit-clock edge on which data changes |
| cfg_line_sel | input | 2 | Data line select, in reversed order |
| smp_data | output | 24 | Received sample, left-aligned |
| smp_chan | output | 4 | Channel or slot number of the sample |
| smp_valid | output | 1 | One-cycle strobe per completed channel |

## Verification
Each format is driven under a mix of polarities and line selects. The unselected lines always carry the inverse of the real data, so a select that is reversed or off by one produces inverted words.

Right-justified streams check the word boundary that sits just before the frame-sync edge. A design that counted from the edge, or that included the bit sampled at the edge, would return a word shifted by one bit.

I2S and left-justified are compared on the same word. A one-bit delay applied to the wrong format shows up directly as a mismatch.

Three further cases are covered:
- A 16-slot frame sent in 8-channel mode must give exactly eight samples.
- A stream with no frame-sync transition must give none.
- The reserved code must stay silent.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 32;
  localparam int MAX_CH   = 16;
  localparam int CHAN_W   = $clog2(MAX_CH);

  typedef enum logic [2:0] {
    FMT_I2S  = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_TDM  = 3'd2,
    FMT_RJ24 = 3'd3,
    FMT_RJ20 = 3'd4,
    FMT_RJ18 = 3'd5,
    FMT_RJ16 = 3'd6,
    FMT_RSVD = 3'd7
  } fmt_e;

  // select code counts down from the highest line
  function automatic logic [1:0] line_of(input logic [1:0] sel);
    return 2'd3 - sel;
  endfunction

  // last N received bits, moved to the top of the sample word
  function automatic logic [SAMPLE_W-1:0] rj_word(input logic [SAMPLE_W-1:0] sh,
                                                  input logic [2:0] fmt);
    case (fmt)
      FMT_RJ20: return {sh[19:0], 4'b0};
      FMT_RJ18: return {sh[17:0], 6'b0};
      FMT_RJ16: return {sh[15:0], 8'b0};
      default:  return sh;
    endcase
  endfunction

  function automatic logic is_rj(input logic [2:0] fmt);
    return (fmt >= FMT_RJ24) && (fmt <= FMT_RJ16);
  endfunction
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic dat_i,
  input  logic bclk_pol,
  output logic samp_evt,
  output logic fs_q,
  output logic dat_q
);
  logic [2:0] chain [STAGES];
  logic       bclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= 3'b000;
      bclk_d <= 1'b0;
    end else begin
      chain[0] <= {bclk_i, fs_i, dat_i};
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      bclk_d <= chain[STAGES-1][2];
    end
  end

  // sample on the edge opposite to the one on which data changes
  assign samp_evt = bclk_pol ? (bclk_d & ~chain[STAGES-1][2])
                             : (~bclk_d & chain[STAGES-1][2]);
  assign fs_q  = chain[STAGES-1][1];
  assign dat_q = chain[STAGES-1][0];

  // R6: clock ratio of four or more keeps sample events apart
  p_evt_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    samp_evt |=> !samp_evt);
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_evt,
  input  logic                fs,
  input  logic                dat,
  input  logic [2:0]          mode,
  input  logic                tdm16,
  input  logic                fs_pol,
  output logic                emit,
  output logic [SAMPLE_W-1:0] word,
  output logic [CHAN_W-1:0]   chan
);
  localparam int SLOT_LSB = $clog2(SLOT_W);
  localparam int SLOT_IW  = CNT_W - SLOT_LSB;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                primed, locked, fs_prev;
  logic [CNT_W-1:0]    pos, pos_nx;
  logic [SAMPLE_W-1:0] shreg, sh_nx;
  logic                act, fs_chg, frm_start, emit_raw;
  logic [SLOT_IW-1:0]  slot, nch;

  assign act       = fs ^ fs_pol;
  assign fs_chg    = primed && (fs != fs_prev);
  assign frm_start = (mode == FMT_TDM) ? (primed && act && !(fs_prev ^ fs_pol)) : fs_chg;
  assign pos_nx    = frm_start ? '0 : ((pos == CNT_MAX) ? CNT_MAX : pos + 1'b1);
  assign sh_nx     = {shreg[SAMPLE_W-2:0], dat};
  assign slot      = pos_nx[CNT_W-1:SLOT_LSB];
  assign nch       = SLOT_IW'(tdm16 ? MAX_CH : MAX_CH / 2);

  always_comb begin
    emit_raw = 1'b0;
    word     = sh_nx;
    chan     = CHAN_W'(act);
    case (mode)
      FMT_I2S: emit_raw = (pos_nx == CNT_W'(SAMPLE_W));
      FMT_LJ:  emit_raw = (pos_nx == CNT_W'(SAMPLE_W - 1));
      FMT_TDM: begin
        emit_raw = (pos_nx[SLOT_LSB-1:0] == SLOT_LSB'(SAMPLE_W - 1)) && (slot < nch);
        chan     = slot[CHAN_W-1:0];
      end
      FMT_RJ24, FMT_RJ20, FMT_RJ18, FMT_RJ16: begin
        emit_raw = fs_chg && locked;
        word     = rj_word(shreg, mode);
        chan     = CHAN_W'(fs_prev ^ fs_pol);
      end
      default: emit_raw = 1'b0;
    endcase
  end
  assign emit = samp_evt && emit_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      locked  <= 1'b0;
      fs_prev <= 1'b0;
      pos     <= CNT_MAX;
      shreg   <= '0;
    end else if (samp_evt) begin
      primed  <= 1'b1;
      fs_prev <= fs;
      pos     <= pos_nx;
      shreg   <= sh_nx;
      if (frm_start) locked <= 1'b1;
    end
  end

  // R9: a channel completes only after a frame boundary was seen
  p_emit_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (locked || frm_start));
  // R4: slot numbers stay below the configured channel count
  p_chan_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && mode == FMT_TDM) |-> (chan < (tdm16 ? CHAN_W'(15) : CHAN_W'(8)) || (tdm16 && chan == CHAN_W'(15))));
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic [3:0]          sdata_i,
  input  logic [2:0]          cfg_mode,
  input  logic                cfg_tdm16,
  input  logic                cfg_fs_pol,
  input  logic                cfg_bclk_pol,
  input  logic [1:0]          cfg_line_sel,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic [CHAN_W-1:0]   smp_chan,
  output logic                smp_valid
);
  logic                dat_sel, samp_evt, fs_q, dat_q, emit;
  logic [SAMPLE_W-1:0] word;
  logic [CHAN_W-1:0]   chan;

  assign dat_sel = sdata_i[line_of(cfg_line_sel)];

  aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fs_i(fsync_i), .dat_i(dat_sel),
    .bclk_pol(cfg_bclk_pol), .samp_evt(samp_evt), .fs_q(fs_q), .dat_q(dat_q)
  );

  aud_rx_deser #(.CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .samp_evt(samp_evt), .fs(fs_q), .dat(dat_q),
    .mode(cfg_mode), .tdm16(cfg_tdm16), .fs_pol(cfg_fs_pol),
    .emit(emit), .word(word), .chan(chan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_chan  <= '0;
    end else begin
      smp_valid <= emit;
      if (emit) begin
        smp_data <= word;
        smp_chan <= chan;
      end
    end
  end

  // R8: one cycle per channel
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  // R8: reserved code stays silent
  p_rsvd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ($past(cfg_mode) != FMT_RSVD));
  // R3: 16-bit right-justified words carry zero low bits
  p_rj16_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(cfg_mode) == FMT_RJ16) |-> (smp_data[7:0] == 8'h00));
endmodule

// File: tb/aud_ser_rx_test.sv
`timescale 1ns/1ps
module aud_ser_rx_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bclk = 1'b0, fs = 1'b0;
  logic [3:0]  sd = 4'h0;
  logic [2:0]  mode = 3'd0;
  logic        tdm16 = 1'b0, fpol = 1'b0, bpol = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [23:0] smp_data;
  logic [3:0]  smp_chan;
  logic        smp_valid;

  int checks = 0, failures = 0;
  int cap_n = 0;
  logic [23:0] cap_w [64];
  logic [3:0]  cap_c [64];

  always #2 clk = ~clk;

  aud_ser_rx uut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fs), .sdata_i(sd),
    .cfg_mode(mode), .cfg_tdm16(tdm16), .cfg_fs_pol(fpol), .cfg_bclk_pol(bpol),
    .cfg_line_sel(sel), .smp_data(smp_data), .smp_chan(smp_chan), .smp_valid(smp_valid)
  );

  always @(negedge clk) if (smp_valid) begin
    if (cap_n < 64) begin
      cap_w[cap_n] = smp_data;
      cap_c[cap_n] = smp_chan;
    end
    cap_n = cap_n + 1;
  end

  // {mode, tdm16, fs_pol, bclk_pol, sel, left word, right word}
  localparam logic [55:0] VEC [10] = '{
    {3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 24'hA5C3F1, 24'h123456},
    {3'd1, 1'b0, 1'b1, 1'b0, 2'd1, 24'h9ABCDE, 24'h7F0011},
    {3'd3, 1'b0, 1'b0, 1'b1, 2'd2, 24'hC0FFEE, 24'h5A5A5A},
    {3'd4, 1'b0, 1'b1, 1'b0, 2'd3, 24'hFEDCBA, 24'h3C3C3C},
    {3'd5, 1'b0, 1'b0, 1'b0, 2'd0, 24'hB7E151, 24'h628AED},
    {3'd6, 1'b0, 1'b1, 1'b1, 2'd1, 24'hDEADBE, 24'h8BADF0},
    {3'd2, 1'b0, 1'b0, 1'b0, 2'd2, 24'h13579B, 24'h000000},
    {3'd2, 1'b1, 1'b1, 1'b1, 2'd3, 24'h2468AC, 24'h000000},
    {3'd7, 1'b0, 1'b0, 1'b0, 2'd0, 24'hFFFFFF, 24'hFFFFFF},
    {3'd0, 1'b0, 1'b1, 1'b1, 2'd3, 24'h6C6C6C, 24'h939393}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive_bit(input logic fsv, input logic dv);
    @(negedge clk);
    bclk = bpol;
    fs = fsv;
    for (int l = 0; l < 4; l++) sd[l] = (l == (3 - int'(sel))) ? dv : ~dv;
    repeat (4) @(negedge clk);
    bclk = ~bpol;
    repeat (3) @(negedge clk);
  endtask

  function automatic int rj_len(input logic [2:0] m);
    case (m)
      3'd3: return 24;
      3'd4: return 20;
      3'd5: return 18;
      default: return 16;
    endcase
  endfunction

  function automatic logic [23:0] rj_mask(input logic [2:0] m);
    return ~(24'hFFFFFF >> rj_len(m));
  endfunction

  task automatic play_half(input logic fsv, input logic [23:0] w);
    for (int i = 0; i < 32; i++) begin
      logic b;
      b = 1'b0;
      if (mode == 3'd0) begin
        if (i >= 1 && i <= 24) b = w[24 - i];
      end else if (mode >= 3'd3 && mode <= 3'd6) begin
        if (i >= 32 - rj_len(mode)) b = w[23 - (i - (32 - rj_len(mode)))];
      end else begin
        if (i < 24) b = w[23 - i];
      end
      drive_bit(fsv, b);
    end
  endtask

  function automatic logic [23:0] slot_word(input logic [23:0] base, input int s);
    return base ^ 24'(s * 24'h0F0F11);
  endfunction

  task automatic play_tdm(input logic [23:0] base, input int slots);
    drive_bit(fpol, 1'b0);
    for (int s = 0; s < slots; s++)
      for (int i = 0; i < 32; i++)
        drive_bit((s == 0 && i == 0) ? ~fpol : fpol, (i < 24) ? slot_word(base, s)[23 - i] : 1'b0);
    drive_bit(fpol, 1'b0);
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    bclk = 1'b0;
    fs = fpol;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cap_n = 0;
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", 32'(smp_valid), 0);
    chk("R9 reset data", 32'(smp_data), 0);
    chk("R9 reset chan", 32'(smp_chan), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      logic [23:0] wl, wr;
      int nch;
      {mode, tdm16, fpol, bpol, sel, wl, wr} = VEC[v];
      restart();
      if (mode == 3'd2) begin
        nch = tdm16 ? 16 : 8;
        play_tdm(wl, nch);
        repeat (12) @(negedge clk);
        chk("R4 R8 tdm count", cap_n, nch);
        for (int s = 0; s < nch && s < cap_n; s++) begin
          chk("R4 R7 tdm word", 32'(cap_w[s]), 32'(slot_word(wl, s)));
          chk("R4 tdm chan", 32'(cap_c[s]), s);
        end
      end else begin
        play_half(~fpol, 24'h0);
        play_half(fpol, wl);
        play_half(~fpol, wr);
        play_half(fpol, 24'h0);
        repeat (12) @(negedge clk);
        if (mode == 3'd7) begin
          chk("R8 reserved silent", cap_n, 0);
        end else if (mode >= 3'd3) begin
          chk("R3 R8 rj count", cap_n, 2);
          if (cap_n >= 2) begin
            chk("R3 R6 R7 rj left word", 32'(cap_w[0]), 32'(wl & rj_mask(mode)));
            chk("R5 rj left chan", 32'(cap_c[0]), 0);
            chk("R3 rj right word", 32'(cap_w[1]), 32'(wr & rj_mask(mode)));
            chk("R5 rj right chan", 32'(cap_c[1]), 1);
          end
        end else begin
          chk(mode == 3'd0 ? "R1 R8 count" : "R2 R8 count", cap_n, 3);
          if (cap_n >= 2) begin
            chk(mode == 3'd0 ? "R1 R6 R7 left word" : "R2 R7 left word", 32'(cap_w[0]), 32'(wl));
            chk("R5 left chan", 32'(cap_c[0]), 0);
            chk(mode == 3'd0 ? "R1 right word" : "R2 right word", 32'(cap_w[1]), 32'(wr));
            chk("R5 right chan", 32'(cap_c[1]), 1);
          end
        end
      end
    end

    // R4: a 16-slot frame in 8-channel mode yields eight samples
    mode = 3'd2; tdm16 = 1'b0; fpol = 1'b0; bpol = 1'b0; sel = 2'd1;
    restart();
    play_tdm(24'h314159, 16);
    repeat (12) @(negedge clk);
    chk("R4 extra slots ignored", cap_n, 8);
    if (cap_n >= 8) chk("R4 last slot word", 32'(cap_w[7]), 32'(slot_word(24'h314159, 7)));

    // R9: no frame-sync transition means no sample
    mode = 3'd1; fpol = 1'b0;
    restart();
    for (int i = 0; i < 48; i++) drive_bit(1'b0, i[0]);
    repeat (12) @(negedge clk);
    chk("R9 no edge no sample", cap_n, 0);

    // R9: reset in the middle of a stream clears outputs
    mode = 3'd1;
    restart();
    play_half(1'b1, 24'h0);
    play_half(1'b0, 24'hABCDEF);
    play_half(1'b1, 24'h0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid reset data", 32'(smp_data), 0);
    chk("R9 mid reset valid", 32'(smp_valid), 0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule